// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Generator

This block derives the bit clock of a synchronous serial port master from the system clock. It uses two counters in cascade. The first counter is a prescaler that only divides by even amounts. The second counter divides the prescaler's output again by one more than a programmed rate code. The output clock runs at the system clock divided by the product of the two stages. It has an exact 50% duty cycle.

Along with the clock level, the block gives two strobes, each one system cycle wide. One marks the rising transition of the bit clock and the other marks the falling transition, so a shifter running on the system clock can act on them. The clock stays low while the block is disabled. New divide settings are taken only at the end of a whole output period, which means a change never produces a short pulse.

Top module: `bitclk_gen`

## Requirements
- R1: With effective prescale P and rate code D, `sclk` toggles every (P/2)·(D+1) enabled system cycles. The full output period is P·(D+1) cycles.
- R2: Bit 0 of `psc_div` is ignored. An odd code divides the same as the even code just below it (5 behaves as 4).
- R3: A `psc_div` of 0 or 1 is treated as a prescale of 2.
- R4: The second stage divides by `rate_sel`+1 over the whole range 0..255. The largest setting (prescale 254, rate code 255) gives a half-period of 32512 cycles.
- R5: While `en` is low, `sclk`, `sclk_rise` and `sclk_fall` are low and both counters are cleared. After `en` rises, `sclk` goes high on the H-th rising clock edge at which `en` is sampled high, where H is the half-period from R1.
- R6: The divide settings are captured only while disabled and at each falling transition of `sclk`. A change in the middle of a period takes effect from the next low phase, and each high phase is as long as the low phase before it.
- R7: `sclk_rise` is high for exactly the cycle in which `sclk` has just gone from 0 to 1. `sclk_fall` is high for exactly the cycle in which it has just gone from 1 to 0. The two strobes are never high together.
- R8: Synchronous reset drives `sclk`, `sclk_rise` and `sclk_fall` low and loads the minimum settings (prescale 2, rate code 0).
- R9: With prescale 2 and rate code 0, `sclk` toggles on every enabled cycle. This gives the smallest total division of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run the bit clock when high |
| psc_div | input | 8 | First-stage prescale code (even, 2..254) |
| rate_sel | input | 8 | Second-stage rate code, divisor is code+1 |
| sclk | output | 1 | Serial bit clock level |
| sclk_rise | output | 1 | One-cycle strobe on the rising transition |
| sclk_fall | output | 1 | One-cycle strobe on the falling transition |

## Verification
The bench builds the block with its default widths: an 8-bit prescale code and an 8-bit rate code. These widths give the real code space. Every odd and sub-minimum prescale code can be applied, and the maximum combined setting of 254×256 can be run through two full half-periods within the cycle budget. Random settings are drawn with a small rate code so that many periods, mid-period setting changes and enable drops fit into one run. Directed cases cover the divide-by-2 floor and the latency of the first edge.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int unsigned BCLK_PSC_W  = 8;
  localparam int unsigned BCLK_RATE_W = 8;
endpackage

// File: rtl/bclk_settings.sv
// Holds the active divide settings; folds the prescale code to an even
// value of at least 2 and stores it as (prescale/2 - 1).
module bclk_settings #(
  parameter int unsigned PSC_W  = bclk_pkg::BCLK_PSC_W,
  parameter int unsigned RATE_W = bclk_pkg::BCLK_RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PSC_W-1:0]  psc_in,
  input  logic [RATE_W-1:0] rate_in,
  output logic [PSC_W-1:0]  half_lim,
  output logic [RATE_W-1:0] rate_lim
);
  logic [PSC_W-1:0] psc_half;
  logic [PSC_W-1:0] psc_lim_next;

  always_comb begin
    psc_half     = psc_in >> 1;
    psc_lim_next = (psc_half == '0) ? '0 : psc_half - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_lim <= '0;
      rate_lim <= '0;
    end else if (load) begin
      half_lim <= psc_lim_next;
      rate_lim <= rate_in;
    end
  end
endmodule

// File: rtl/bclk_prescale.sv
// First stage: emits one tick every (lim+1) running cycles.
module bclk_prescale #(
  parameter int unsigned W = bclk_pkg::BCLK_PSC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] lim,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bclk_rate.sv
// Second stage: counts first-stage ticks, wraps after (lim+1) of them.
module bclk_rate #(
  parameter int unsigned W = bclk_pkg::BCLK_RATE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = tick && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || wrap) cnt <= '0;
    else if (tick)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen #(
  parameter int unsigned PSC_W  = bclk_pkg::BCLK_PSC_W,
  parameter int unsigned RATE_W = bclk_pkg::BCLK_RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PSC_W-1:0]  psc_div,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              sclk,
  output logic              sclk_rise,
  output logic              sclk_fall
);
  logic [PSC_W-1:0]  half_lim;
  logic [RATE_W-1:0] rate_lim;
  logic              pre_tick;
  logic              half_done;
  logic              cfg_load;

  // settings move only while idle or as the clock falls (end of a period)
  assign cfg_load = !en || (half_done && sclk);

  bclk_settings #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .psc_in(psc_div), .rate_in(rate_sel),
    .half_lim(half_lim), .rate_lim(rate_lim)
  );

  bclk_prescale #(.W(PSC_W)) u_pre (
    .clk(clk), .rst(rst), .run(en), .lim(half_lim), .tick(pre_tick)
  );

  bclk_rate #(.W(RATE_W)) u_rate (
    .clk(clk), .rst(rst), .run(en), .tick(pre_tick), .lim(rate_lim),
    .wrap(half_done)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sclk      <= 1'b0;
      sclk_rise <= 1'b0;
      sclk_fall <= 1'b0;
    end else begin
      sclk      <= sclk ^ half_done;
      sclk_rise <= half_done && !sclk;
      sclk_fall <= half_done && sclk;
    end
  end
endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic sclk,
  input logic sclk_rise,
  input logic sclk_fall
);
  a_r7_rise_marks_edge: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |-> (sclk && !$past(sclk)));

  a_r7_fall_marks_edge: assert property (@(posedge clk) disable iff (rst)
    sclk_fall |-> (!sclk && $past(sclk)));

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({sclk_rise, sclk_fall}) <= 1);

  a_r7_change_has_strobe: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && (sclk != $past(sclk))) |-> (sclk_rise || sclk_fall));

  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sclk && !sclk_rise && !sclk_fall));

  a_r8_reset_low: assert property (@(posedge clk)
    rst |=> (!sclk && !sclk_rise && !sclk_fall));
endmodule

bind bitclk_gen bitclk_gen_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .sclk(sclk),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
);

// File: tb/bitclk_gen_test.sv
module bitclk_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] psc_div = 8'd2;
  logic [7:0] rate_sel = 8'd0;
  logic       sclk, sclk_rise, sclk_fall;

  int checks = 0;
  int fails  = 0;

  // reference state, built from the requirements
  logic m_sclk = 1'b0, m_rise = 1'b0, m_fall = 1'b0;
  int   m_cnt = 0;
  int   m_h   = 1;

  always #2 clk = ~clk;

  bitclk_gen uut (
    .clk(clk), .rst(rst), .en(en), .psc_div(psc_div), .rate_sel(rate_sel),
    .sclk(sclk), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  // R1/R2/R3/R4: half-period in system cycles
  function automatic int half_of(input logic [7:0] p, input logic [7:0] r);
    int pe;
    pe = int'(p) & 32'hFE;
    if (pe < 2) pe = 2;
    return (pe / 2) * (int'(r) + 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sclk <= 1'b0; m_rise <= 1'b0; m_fall <= 1'b0; m_cnt <= 0; m_h <= 1;
    end else if (!en) begin
      m_sclk <= 1'b0; m_rise <= 1'b0; m_fall <= 1'b0; m_cnt <= 0;
      m_h <= half_of(psc_div, rate_sel);
    end else if (m_cnt + 1 == m_h) begin
      m_sclk <= !m_sclk; m_rise <= !m_sclk; m_fall <= m_sclk; m_cnt <= 0;
      if (m_sclk) m_h <= half_of(psc_div, rate_sel);
    end else begin
      m_rise <= 1'b0; m_fall <= 1'b0; m_cnt <= m_cnt + 1;
    end
  end

  task automatic cmp(input string tag);
    checks++;
    if ({sclk, sclk_rise, sclk_fall} !== {m_sclk, m_rise, m_fall}) begin
      fails++;
      $display("FAIL %s: sclk/rise/fall got %b%b%b expected %b%b%b at %0t",
               tag, sclk, sclk_rise, sclk_fall, m_sclk, m_rise, m_fall, $time);
    end
  endtask

  task automatic step(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(tag);
    end
  endtask

  task automatic expect_int(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    int h;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);

    // R8: reset state
    step(3, "R8");
    @(negedge clk); rst = 1'b0;
    step(2, "R8");

    // R9: floor division of 2
    psc_div = 8'd2; rate_sel = 8'd0; step(2, "R9");
    en = 1'b1; step(12, "R9");
    en = 1'b0; step(2, "R5");

    // R3: sub-minimum prescale codes
    psc_div = 8'd0; rate_sel = 8'd0; step(1, "R3");
    en = 1'b1; step(10, "R3");
    en = 1'b0; psc_div = 8'd1; rate_sel = 8'd2; step(2, "R3");
    en = 1'b1; step(16, "R3");
    en = 1'b0; step(2, "R5");

    // R2 + R1: odd code, explicit period between rises = 4*4 = 16
    psc_div = 8'd5; rate_sel = 8'd3; step(2, "R2");
    en = 1'b1;
    n = 0;
    do begin step(1, "R2"); n++; end while (!sclk_rise && n < 100);
    n = 0;
    do begin step(1, "R1"); n++; end while (!sclk_rise && n < 100);
    expect_int(n, 16, "R1 period psc5 rate3");
    en = 1'b0; step(2, "R5");

    // R5: first rise on H-th enabled edge (psc 6, rate 1 -> H 6)
    psc_div = 8'd6; rate_sel = 8'd1; step(2, "R5");
    en = 1'b1;
    n = 0;
    do begin step(1, "R5"); n++; end while (!sclk && n < 100);
    expect_int(n, 6, "R5 first edge latency");
    step(3, "R5");
    en = 1'b0; step(1, "R5");  // drop while high
    expect_int(int'(sclk), 0, "R5 idle level after drop");
    step(2, "R5");

    // R6: mid-period change (H 4 -> H 12)
    psc_div = 8'd4; rate_sel = 8'd1; step(2, "R6");
    en = 1'b1; step(3, "R6");
    psc_div = 8'd8; rate_sel = 8'd2; step(40, "R6");
    en = 1'b0; step(2, "R6");

    // R4: largest setting, H = 127*256 = 32512
    psc_div = 8'd254; rate_sel = 8'd255; step(2, "R4");
    en = 1'b1; step(2 * 32512 + 4, "R4");
    en = 1'b0; step(2, "R4");

    // R1/R6/R7: random settings, mid-run changes, enable drops
    for (int k = 0; k < 16; k++) begin
      psc_div  = 8'($urandom);
      rate_sel = 8'($urandom & 7);
      step(2, "R1");
      h = half_of(psc_div, rate_sel);
      en = 1'b1; step(2 * h + 3, "R7");
      psc_div  = 8'($urandom);
      rate_sel = 8'($urandom & 7);
      if (half_of(psc_div, rate_sel) > h) h = half_of(psc_div, rate_sel);
      step(3 * h, "R6");
      if (($urandom & 1) == 1) begin en = 1'b0; step(2, "R5"); end
    end
    en = 1'b0; step(2, "R5");

    summary();
    $finish;
  end
endmodule